// File: doc/BRIEF.md
# Byte Store Execution Unit

This unit executes one single-byte store per issue. It receives a 32-bit instruction word, the register values selected by the register indices it drives out, and the current N/Z/C/V flags. It evaluates the instruction's condition code and either cancels the store or carries it out. When it carries it out, it forms an offset from either a 12-bit immediate or a shifted register, adds or subtracts that offset to or from the base, and picks the pre-indexed or post-indexed address for the access.

The result is registered one cycle after issue. It consists of a byte write with a one-hot lane strobe, the low source byte copied onto all four lanes of a 32-bit bus, a base register writeback, and a data abort flag. The abort fires when the access address falls outside a legal window set by parameters. An abort blocks both the memory write and the writeback. The register indices come straight from the instruction, so the surrounding pipeline can read its register file in the issue cycle.

Top module: `bytestore_exec`

## Requirements
- R1: The unit acts only on a well-formed byte store: bits 27:26 = 01, bit 22 = 1 and bit 20 = 0. Any other word gives no strobe, no writeback and no abort.
- R2: Condition code bits 31:28 decode as follows: 0 EQ (Z), 1 NE (!Z), 2 CS (C), 3 CC (!C), 4 MI (N), 5 PL (!N), 6 VS (V), 7 VC (!V), 8 HI (C&!Z), 9 LS (!C|Z), 10 GE (N==V), 11 LT (N!=V), 12 GT (!Z&N==V), 13 LE (Z|N!=V), 14 always, 15 never. The flags input packs N,Z,C,V into bits 3..0.
- R3: A store whose condition fails gives no strobe, no base writeback and no abort.
- R4: When bit 25 = 0, the offset is the zero-extended immediate in bits 11:0. When bit 23 = 1 the offset is added to the base; when bit 23 = 0 it is subtracted.
- R5: When bit 25 = 1, the offset is the register named by bits 3:0, shifted by the amount in bits 11:7 with the shift type in bits 6:5 (00 LSL, 01 LSR, 10 ASR, 11 ROR). An amount of 0 means: LSL unchanged, LSR gives 0, ASR fills with the sign bit, ROR becomes a 33-bit rotate through C (C enters at bit 31).
- R6: When bit 24 = 1 (pre-indexed), the access uses base±offset and the base is written back only if bit 21 = 1. When bit 24 = 0 (post-indexed), the access uses the unmodified base and the base is always written back.
- R7: The strobe has exactly bit n set for access address bits 1:0 = n. The write data is bits 7:0 of the source register copied to all four bytes; bits 31:8 of the source have no effect.
- R8: An access address below ADDR_LO or above ADDR_HI raises abort, and the strobe and writeback stay clear.
- R9: Results appear with res_valid on the cycle after issue_valid. While res_valid is low, the strobe, writeback enable and abort are all low.
- R10: mem_addr shows the access address, wb_reg shows bits 19:16, and wb_value shows base±offset. The register index outputs show bits 19:16, 15:12 and 3:0 of the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction word and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| flags | input | 4 | N,Z,C,V in bits 3..0 |
| rd_base_sel | output | 4 | Index of base register to read |
| rd_src_sel | output | 4 | Index of source register to read |
| rd_off_sel | output | 4 | Index of offset register to read |
| base_val | input | 32 | Base register value |
| src_val | input | 32 | Source register value |
| offreg_val | input | 32 | Offset register value |
| res_valid | output | 1 | Result of the previous issue is valid |
| mem_strobe | output | 4 | One-hot byte lane write strobe |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Low source byte copied to all lanes |
| wb_en | output | 1 | Base register writeback enable |
| wb_reg | output | 4 | Base register index to write back |
| wb_value | output | 32 | Base±offset writeback value |
| abort | output | 1 | Data abort for an access outside the window |

## Verification
The bench builds the unit with a legal window of 0x1000 to 0xFFFF instead of the default full address space. This places addresses just below, inside and far above the window within easy reach. It therefore lets aborts be raised on both sides by pre-indexed subtraction, by post-indexed access and by large rotated offsets. It also shows that a post-indexed store is judged by the unmodified base even when the written-back base leaves the window.

// File: rtl/bse_pkg.sv
package bse_pkg;
  localparam int DW = 32;

  typedef enum logic [1:0] {
    SH_LSL = 2'b00,
    SH_LSR = 2'b01,
    SH_ASR = 2'b10,
    SH_ROR = 2'b11
  } shift_kind_t;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

  typedef enum logic [3:0] {
    CC_EQ, CC_NE, CC_CS, CC_CC, CC_MI, CC_PL, CC_VS, CC_VC,
    CC_HI, CC_LS, CC_GE, CC_LT, CC_GT, CC_LE, CC_AL, CC_NV
  } cond_code_t;
endpackage

// File: rtl/bse_cond.sv
module bse_cond
  import bse_pkg::*;
(
  input  logic [3:0] code,
  input  nzcv_t      fl,
  output logic       pass
);
  always_comb begin
    unique case (cond_code_t'(code))
      CC_EQ: pass = fl.z;
      CC_NE: pass = !fl.z;
      CC_CS: pass = fl.c;
      CC_CC: pass = !fl.c;
      CC_MI: pass = fl.n;
      CC_PL: pass = !fl.n;
      CC_VS: pass = fl.v;
      CC_VC: pass = !fl.v;
      CC_HI: pass = fl.c && !fl.z;
      CC_LS: pass = !fl.c || fl.z;
      CC_GE: pass = (fl.n == fl.v);
      CC_LT: pass = (fl.n != fl.v);
      CC_GT: pass = !fl.z && (fl.n == fl.v);
      CC_LE: pass = fl.z || (fl.n != fl.v);
      CC_AL: pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  // R2: the always and never codes ignore the flags
  always_comb begin
    a_r2_always_never: assert (!(code == 4'd14 && !pass) && !(code == 4'd15 && pass));
  end
endmodule

// File: rtl/bse_shifter.sv
module bse_shifter
  import bse_pkg::*;
#(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  val,
  input  logic [SW-1:0] amt,
  input  logic [1:0]    kind,
  input  logic          carry_in,
  output logic [W-1:0]  res
);
  logic [2*W-1:0] rot_wide;
  logic           zero_amt;

  assign zero_amt = (amt == '0);
  assign rot_wide = {val, val} >> amt;

  always_comb begin
    unique case (shift_kind_t'(kind))
      SH_LSL: res = val << amt;
      SH_LSR: res = zero_amt ? '0 : (val >> amt);
      SH_ASR: res = zero_amt ? {W{val[W-1]}} : W'($signed(val) >>> amt);
      default: res = zero_amt ? {carry_in, val[W-1:1]} : rot_wide[W-1:0];
    endcase
  end
endmodule

// File: rtl/bse_addr_gen.sv
module bse_addr_gen #(
  parameter int W = 32
) (
  input  logic [W-1:0] base,
  input  logic [W-1:0] offset,
  input  logic         up,
  input  logic         pre,
  output logic [W-1:0] idx_addr,
  output logic [W-1:0] acc_addr
);
  assign idx_addr = up ? (base + offset) : (base - offset);
  assign acc_addr = pre ? idx_addr : base;

  // R6: post-indexed access never moves away from the base
  always_comb begin
    a_r6_post_uses_base: assert (pre || (acc_addr == base));
  end
endmodule

// File: rtl/bytestore_exec.sv
module bytestore_exec
  import bse_pkg::*;
#(
  parameter logic [31:0] ADDR_LO = 32'h0000_0000,
  parameter logic [31:0] ADDR_HI = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue_valid,
  input  logic [31:0] instr,
  input  logic [3:0]  flags,
  output logic [3:0]  rd_base_sel,
  output logic [3:0]  rd_src_sel,
  output logic [3:0]  rd_off_sel,
  input  logic [31:0] base_val,
  input  logic [31:0] src_val,
  input  logic [31:0] offreg_val,
  output logic        res_valid,
  output logic [3:0]  mem_strobe,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  output logic        wb_en,
  output logic [3:0]  wb_reg,
  output logic [31:0] wb_value,
  output logic        abort
);
  localparam int SW = $clog2(DW);
  localparam int LANES = DW / 8;

  // instruction fields
  logic        f_imm_n, f_pre, f_up, f_wback, well_formed;
  logic [11:0] f_imm;
  nzcv_t       fl;

  assign f_imm_n     = instr[25];
  assign f_pre       = instr[24];
  assign f_up        = instr[23];
  assign f_wback     = instr[21];
  assign f_imm       = instr[11:0];
  assign well_formed = (instr[27:26] == 2'b01) && instr[22] && !instr[20];
  assign fl          = nzcv_t'(flags);

  assign rd_base_sel = instr[19:16];
  assign rd_src_sel  = instr[15:12];
  assign rd_off_sel  = instr[3:0];

  logic          cond_ok;
  logic [DW-1:0] shifted, offset, idx_addr, acc_addr;

  bse_cond u_cond (
    .code (instr[31:28]),
    .fl   (fl),
    .pass (cond_ok)
  );

  bse_shifter #(.W(DW)) u_shift (
    .val      (offreg_val),
    .amt      (instr[11:7]),
    .kind     (instr[6:5]),
    .carry_in (fl.c),
    .res      (shifted)
  );

  assign offset = f_imm_n ? shifted : {{(DW-12){1'b0}}, f_imm};

  bse_addr_gen #(.W(DW)) u_agen (
    .base     (base_val),
    .offset   (offset),
    .up       (f_up),
    .pre      (f_pre),
    .idx_addr (idx_addr),
    .acc_addr (acc_addr)
  );

  // next-state logic
  logic             go, out_of_win;
  logic             valid_d, abort_d, wb_en_d;
  logic [LANES-1:0] strobe_d;
  logic [DW-1:0]    wdata_d;

  assign go         = issue_valid && well_formed && cond_ok;
  assign out_of_win = (acc_addr < ADDR_LO) || (acc_addr > ADDR_HI);

  always_comb begin
    valid_d  = issue_valid;
    abort_d  = go && out_of_win;
    wb_en_d  = go && !out_of_win && (!f_pre || f_wback);
    strobe_d = '0;
    if (go && !out_of_win) begin
      strobe_d[acc_addr[SW-4:0]] = 1'b1;
    end
    wdata_d = {LANES{src_val[7:0]}};
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      mem_strobe <= '0;
      wb_en      <= 1'b0;
      abort      <= 1'b0;
    end else begin
      res_valid  <= valid_d;
      mem_strobe <= strobe_d;
      wb_en      <= wb_en_d;
      abort      <= abort_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      wb_reg    <= '0;
      wb_value  <= '0;
    end else if (issue_valid) begin
      mem_addr  <= acc_addr;
      mem_wdata <= wdata_d;
      wb_reg    <= instr[19:16];
      wb_value  <= idx_addr;
    end
  end

  // R9: nothing leaves the unit without a valid result
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (mem_strobe == '0) && !wb_en && !abort);

  // R9: a result follows an issue by exactly one cycle
  a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(issue_valid));

  // R7: at most one byte lane written
  a_r7_lane_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mem_strobe));

  // R8: an abort suppresses write and writeback
  a_r8_abort_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (mem_strobe == '0) && !wb_en);

  // R8: every write lands inside the legal window
  a_r8_write_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (|mem_strobe) |-> (mem_addr >= ADDR_LO) && (mem_addr <= ADDR_HI));
endmodule

// File: tb/tb_bytestore_exec.sv
module tb_bytestore_exec;
  localparam logic [31:0] LO = 32'h0000_1000;
  localparam logic [31:0] HI = 32'h0000_FFFF;

  logic        clk, rst_n, issue_valid;
  logic [31:0] instr;
  logic [3:0]  flags;
  logic [3:0]  rd_base_sel, rd_src_sel, rd_off_sel;
  logic [31:0] base_val, src_val, offreg_val;
  logic        res_valid, wb_en, abort;
  logic [3:0]  mem_strobe, wb_reg;
  logic [31:0] mem_addr, mem_wdata, wb_value;

  logic [31:0] rf [16];

  assign base_val   = rf[rd_base_sel];
  assign src_val    = rf[rd_src_sel];
  assign offreg_val = rf[rd_off_sel];

  bytestore_exec #(.ADDR_LO(LO), .ADDR_HI(HI)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .instr(instr),
    .flags(flags), .rd_base_sel(rd_base_sel), .rd_src_sel(rd_src_sel),
    .rd_off_sel(rd_off_sel), .base_val(base_val), .src_val(src_val),
    .offreg_val(offreg_val), .res_valid(res_valid), .mem_strobe(mem_strobe),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wb_en(wb_en),
    .wb_reg(wb_reg), .wb_value(wb_value), .abort(abort)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct {
    logic [3:0]  strobe;
    logic [31:0] addr;
    logic [31:0] wdata;
    logic        wb_en;
    logic [3:0]  wb_reg;
    logic [31:0] wb_val;
    logic        abort;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] cc, input logic i,
      input logic p, input logic u, input logic w, input logic [3:0] rn,
      input logic [3:0] rd, input logic [11:0] off);
    return {cc, 2'b01, i, p, u, 1'b1, w, 1'b0, rn, rd, off};
  endfunction

  function automatic logic [11:0] sreg(input logic [4:0] amt,
      input logic [1:0] kind, input logic [3:0] rm);
    return {amt, kind, 1'b0, rm};
  endfunction

  // reference model written from the requirements
  function automatic exp_t model(input logic [31:0] w, input logic [3:0] f,
                                 input string tag);
    exp_t e;
    logic n, z, c, v, ok, pass, oob;
    logic [31:0] b, off, x, idx, acc;
    int sh;
    {n, z, c, v} = f;
    ok = (w[27:26] == 2'b01) && w[22] && !w[20];
    case (w[31:28])
      0: pass = z;        1: pass = !z;
      2: pass = c;        3: pass = !c;
      4: pass = n;        5: pass = !n;
      6: pass = v;        7: pass = !v;
      8: pass = c && !z;  9: pass = !c || z;
      10: pass = n == v;  11: pass = n != v;
      12: pass = !z && n == v;
      13: pass = z || n != v;
      14: pass = 1;
      default: pass = 0;
    endcase
    b = rf[w[19:16]];
    x = rf[w[3:0]];
    sh = int'(w[11:7]);
    if (!w[25]) off = {20'd0, w[11:0]};
    else case (w[6:5])
      2'b00: off = x << sh;
      2'b01: off = (sh == 0) ? 32'd0 : x >> sh;
      2'b10: off = (sh == 0) ? {32{x[31]}} : 32'($signed(x) >>> sh);
      default: off = (sh == 0) ? {c, x[31:1]} : ((x >> sh) | (x << (32 - sh)));
    endcase
    idx = w[23] ? b + off : b - off;
    acc = w[24] ? idx : b;
    oob = (acc < LO) || (acc > HI);
    e.addr   = acc;
    e.wdata  = {4{rf[w[15:12]][7:0]}};
    e.wb_reg = w[19:16];
    e.wb_val = idx;
    e.abort  = ok && pass && oob;
    e.wb_en  = ok && pass && !oob && (!w[24] || w[21]);
    e.strobe = (ok && pass && !oob) ? (4'b0001 << acc[1:0]) : 4'b0000;
    e.tag    = tag;
    return e;
  endfunction

  // driver: loads operands, drives one issue, pushes the expectation
  task automatic issue(input logic [31:0] w, input logic [3:0] f,
      input logic [31:0] bv, input logic [31:0] sv, input logic [31:0] ov,
      input string tag);
    @(negedge clk);
    rf[w[3:0]]   = ov;
    rf[w[15:12]] = sv;
    rf[w[19:16]] = bv;
    instr       = w;
    flags       = f;
    issue_valid = 1'b1;
    sb.push_back(model(w, f, tag));
  endtask

  // monitor: pops and compares each result
  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      if (sb.size() == 0) begin
        check("R9", "unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "strobe", {28'd0, mem_strobe}, {28'd0, e.strobe});
        check(e.tag, "addr", mem_addr, e.addr);
        check(e.tag, "wdata", mem_wdata, e.wdata);
        check(e.tag, "wb_en", {31'd0, wb_en}, {31'd0, e.wb_en});
        check(e.tag, "wb_reg", {28'd0, wb_reg}, {28'd0, e.wb_reg});
        check(e.tag, "wb_value", wb_value, e.wb_val);
        check(e.tag, "abort", {31'd0, abort}, {31'd0, e.abort});
      end
    end else if (rst_n) begin
      check("R9", "idle outputs", {27'd0, mem_strobe, wb_en, abort}, 32'd0);
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) rf[i] = 32'h0;
    rst_n = 1'b0; issue_valid = 1'b0; instr = '0; flags = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9", "reset valid", {31'd0, res_valid}, 32'd0);
    check("R9", "reset strobe", {28'd0, mem_strobe}, 32'd0);
    rst_n = 1'b1;

    // R10 R4 R7: immediate pre-indexed, no writeback
    issue(32'hE5CA801C, 4'b0000, 32'h2000, 32'h1234_56AB, 32'h0, "R4");
    // R5 R6: post-indexed, ROR 8 register offset
    issue(32'hE6C41462, 4'b0000, 32'h3001, 32'hFFFF_FF5A, 32'h0000_00FF, "R6");
    // R7: plain store, lane 3
    issue(32'hE5C30000, 4'b0000, 32'h4003, 32'hAAAA_0077, 32'h0, "R7");
    // R2 R3: EQ fails with Z clear, passes with Z set
    issue(32'h05CA801C, 4'b0000, 32'h2000, 32'h11, 32'h0, "R3");
    issue(32'h05CA801C, 4'b0100, 32'h2000, 32'h22, 32'h0, "R2");
    // R2: code 15 never executes
    issue(32'hF5CA801C, 4'b1111, 32'h2000, 32'h33, 32'h0, "R2");
    // R2: every code against several flag patterns
    for (int cc = 0; cc < 16; cc++) begin
      for (int fv = 0; fv < 16; fv += 5) begin
        issue(enc(4'(cc), 0, 1, 1, 0, 4'd5, 4'd6, 12'h002),
              4'(fv), 32'h5000, 32'h44, 32'h0, "R2");
      end
    end
    // R1: load bit, word bit, wrong class
    issue(32'hE5DA801C, 4'b0000, 32'h2000, 32'h55, 32'h0, "R1");
    issue(32'hE58A801C, 4'b0000, 32'h2000, 32'h55, 32'h0, "R1");
    issue(32'hE9CA801C, 4'b0000, 32'h2000, 32'h55, 32'h0, "R1");
    // R4 R6: pre-indexed subtract with writeback
    issue(enc(4'hE, 0, 1, 0, 1, 4'd7, 4'd9, 12'h0FF), 4'b0, 32'h2101, 32'h66, 32'h0, "R6");
    // R5: shift kinds and zero-amount special cases
    issue(enc(4'hE, 1, 1, 1, 0, 4'd1, 4'd2, sreg(5'd4, 2'b00, 4'd3)), 4'b0, 32'h1000, 32'h1, 32'h0000_0012, "R5");
    issue(enc(4'hE, 1, 1, 1, 0, 4'd1, 4'd2, sreg(5'd0, 2'b01, 4'd3)), 4'b0, 32'h1000, 32'h1, 32'hFFFF_FFFF, "R5");
    issue(enc(4'hE, 1, 1, 1, 0, 4'd1, 4'd2, sreg(5'd0, 2'b10, 4'd3)), 4'b0, 32'h1004, 32'h1, 32'h8000_0000, "R5");
    issue(enc(4'hE, 1, 1, 0, 0, 4'd1, 4'd2, sreg(5'd0, 2'b10, 4'd3)), 4'b0, 32'h1004, 32'h1, 32'h8000_0000, "R5");
    issue(enc(4'hE, 1, 1, 1, 0, 4'd1, 4'd2, sreg(5'd0, 2'b11, 4'd3)), 4'b0010, 32'h1000, 32'h1, 32'h0000_0010, "R5");
    issue(enc(4'hE, 1, 1, 1, 0, 4'd1, 4'd2, sreg(5'd3, 2'b10, 4'd3)), 4'b0, 32'h1000, 32'h1, 32'hFFFF_FF00, "R5");
    // R8: below window, above window, post-indexed judged on base
    issue(enc(4'hE, 0, 1, 0, 1, 4'd8, 4'd9, 12'h001), 4'b0, 32'h1000, 32'h77, 32'h0, "R8");
    issue(enc(4'hE, 0, 1, 1, 1, 4'd8, 4'd9, 12'h001), 4'b0, 32'hFFFF, 32'h77, 32'h0, "R8");
    issue(enc(4'hE, 0, 0, 1, 0, 4'd8, 4'd9, 12'hFFF), 4'b0, 32'hFFFE, 32'h88, 32'h0, "R8");
    issue(enc(4'hE, 0, 0, 1, 0, 4'd8, 4'd9, 12'h004), 4'b0, 32'h0FFF, 32'h88, 32'h0, "R8");
    // R7: each lane
    for (int ln = 0; ln < 4; ln++) begin
      issue(enc(4'hE, 0, 0, 1, 0, 4'd11, 4'd12, 12'h010), 4'b0,
            32'h8000 + 32'(ln), 32'hDEAD_BE00 + 32'(ln), 32'h0, "R7");
    end

    @(negedge clk);
    issue_valid = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "scoreboard drained", 32'(sb.size()), 32'd0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule